// File: doc/BRIEF.md
# Acknowledged Link Transfer Between Neighbouring Switches

This block carries one word at a time across a single link between two adjacent mesh switches. The sending half sits in the output stage of one switch and the receiving half in the input stage of the next. Between them run three lines: a destination identifier and a data word travel downstream, and a one-bit acknowledge travels back upstream. Delivery is speculative. The sender pushes a word without first holding any credit. The receiver quietly throws the word away when the addressed buffer is full. The sender learns the result one cycle later and either retires its head word or keeps it so that a later grant can retry it.

A transfer takes four single-cycle steps. In the first, an external arbiter grants one virtual channel. In the second, the identifier of the destination buffer goes out. In the third, the word goes out and the receiver answers at once. In the fourth, the sender acts on that answer. Each step belongs to a different transfer at any moment, so a new grant can be accepted every cycle. The buffers themselves, the routing table and the arbiter lie outside the block. They are reached through per-channel request, routing and head-word inputs, per-buffer free-slot inputs and a write strobe.

Top module: `lnk_xfer_top`

## Requirements
- R1: A grant accepted in cycle t gives the address valid in cycle t+1, the data valid in cycle t+2, and exactly one of done or retry in cycle t+3.
- R2: In the address cycle, the address line carries the routing entry of the granted channel. When no transfer is in that step, the address valid is low and the address line is zero.
- R3: In the data cycle, the data line carries that channel's head word. When no transfer is in that step, the data valid is low and the data line is zero.
- R4: In the data cycle, the acknowledge is high exactly when the addressed buffer has room. In every cycle without a data valid, the acknowledge is low.
- R5: The receiver raises its write strobe only together with a high acknowledge. The strobe carries the word from the data line. The identifier splits as buffer number = direction × 4 + index: the upper two bits are the source direction and the lower two bits are the index within that direction's memory.
- R6: The free-slot input of a buffer does not yet count a write made in the immediately preceding cycle. When the preceding cycle wrote the same buffer, room means at least two free slots. Otherwise room means at least one.
- R7: In the fourth step, done is raised on a true acknowledge and retry on a false one. Both report the channel of that transfer, and never both are high in the same cycle.
- R8: One grant can be accepted every cycle. A grant for a channel that still has a transfer in the address or data step is ignored and launches nothing.
- R9: While reset is asserted, the address valid, data valid, acknowledge, write strobe, done and retry are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_vld_i | input | 1 | Arbiter grants a channel this cycle |
| arb_vc_i | input | 2 | Granted channel number |
| route_tbl_i | input | 16 | Destination identifier for each channel, 4 bits per channel |
| head_data_i | input | 64 | Head word of each channel, 16 bits per channel |
| tx_done_o | output | 1 | Transfer acknowledged; the channel drops its head word |
| tx_retry_o | output | 1 | Transfer refused; the channel keeps its head word |
| tx_vc_o | output | 2 | Channel that done or retry refers to |
| lnk_addr_vld_o | output | 1 | Link address step active |
| lnk_addr_o | output | 4 | Link destination identifier |
| lnk_data_vld_o | output | 1 | Link data step active |
| lnk_data_o | output | 16 | Link data word |
| lnk_ack_o | output | 1 | Link acknowledge returned upstream |
| rx_free_i | input | 64 | Free-slot count of each receive buffer, 4 bits per buffer |
| rx_wr_en_o | output | 1 | Store the link word into a receive buffer |
| rx_wr_dir_o | output | 2 | Source-direction memory of the write |
| rx_wr_idx_o | output | 2 | Buffer index within that memory |
| rx_wr_data_o | output | 16 | Word written |

## Verification
The assertions check several rules on every cycle. Every address step is followed by a data step. Every data step is followed by exactly one of done or retry, and done agrees with the acknowledge returned in the cycle before. The acknowledge and the write strobe never appear without a data valid. A second write to the same buffer on consecutive cycles only happens when at least two slots were reported free. Other behaviours can only be shown by the bench's scenarios, using its cycle reference model. These are the actual values: which routing entry and which head word go out, whether a full or a same-buffer case is refused, that a grant colliding with an in-flight channel is dropped, and that each channel's words arrive in order with no loss after retries.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  // Index width that stays at least one bit for single-entry structures.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Acknowledge line polarity.
  localparam logic ACK_TAKEN = 1'b1;

endpackage

// File: rtl/lnk_id_dec.sv
// Splits a destination identifier into the source-direction memory and
// the buffer index inside that memory (identifier = dir * BUF_PER_MEM + idx).
module lnk_id_dec #(
  parameter int NUM_DIR     = 4,
  parameter int BUF_PER_MEM = 4
) (
  input  logic [lnk_pkg::idx_w(NUM_DIR*BUF_PER_MEM)-1:0] id_i,
  output logic [lnk_pkg::idx_w(NUM_DIR)-1:0]             dir_o,
  output logic [lnk_pkg::idx_w(BUF_PER_MEM)-1:0]         idx_o
);
  localparam int DIR_W = lnk_pkg::idx_w(NUM_DIR);
  localparam int IDX_W = lnk_pkg::idx_w(BUF_PER_MEM);

  always_comb begin
    dir_o = DIR_W'(int'(id_i) / BUF_PER_MEM);
    idx_o = IDX_W'(int'(id_i) % BUF_PER_MEM);
  end
endmodule

// File: rtl/lnk_tx.sv
// Sending half: grant -> address step -> data step -> acknowledge step.
module lnk_tx #(
  parameter int NUM_VC = 4,
  parameter int DW     = 16,
  parameter int ID_W   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              grant_vld_i,
  input  logic [lnk_pkg::idx_w(NUM_VC)-1:0] grant_vc_i,
  input  logic [NUM_VC*ID_W-1:0]            route_i,
  input  logic [NUM_VC*DW-1:0]              head_i,
  input  logic                              ack_i,
  output logic                              addr_vld_o,
  output logic [ID_W-1:0]                   addr_o,
  output logic                              data_vld_o,
  output logic [DW-1:0]                     data_o,
  output logic                              done_o,
  output logic                              retry_o,
  output logic [lnk_pkg::idx_w(NUM_VC)-1:0] done_vc_o
);
  localparam int VC_W = lnk_pkg::idx_w(NUM_VC);

  logic [ID_W-1:0] route_arr [NUM_VC];
  logic [DW-1:0]   head_arr  [NUM_VC];

  generate
    for (genvar g = 0; g < NUM_VC; g++) begin : g_unpack
      assign route_arr[g] = route_i[g*ID_W +: ID_W];
      assign head_arr[g]  = head_i[g*DW +: DW];
    end
  endgenerate

  // Stage registers: a = address step, d = data step, k = acknowledge step.
  logic            a_vld_q, d_vld_q, k_vld_q, k_ack_q;
  logic [VC_W-1:0] a_vc_q, d_vc_q, k_vc_q;
  logic            clash, launch;

  // Next-state logic.
  always_comb begin
    clash  = (a_vld_q && (a_vc_q == grant_vc_i)) ||
             (d_vld_q && (d_vc_q == grant_vc_i));
    launch = grant_vld_i && !clash;
  end

  // Valid pipeline.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld_q <= 1'b0;
      d_vld_q <= 1'b0;
      k_vld_q <= 1'b0;
    end else begin
      a_vld_q <= launch;
      d_vld_q <= a_vld_q;
      k_vld_q <= d_vld_q;
    end
  end

  // Payload pipeline with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vc_q  <= '0;
      d_vc_q  <= '0;
      k_vc_q  <= '0;
      k_ack_q <= 1'b0;
    end else begin
      if (launch) a_vc_q <= grant_vc_i;
      if (a_vld_q) d_vc_q <= a_vc_q;
      if (d_vld_q) begin
        k_vc_q  <= d_vc_q;
        k_ack_q <= ack_i;
      end
    end
  end

  // Link and response outputs.
  always_comb begin
    addr_vld_o = a_vld_q;
    addr_o     = a_vld_q ? route_arr[a_vc_q] : '0;
    data_vld_o = d_vld_q;
    data_o     = d_vld_q ? head_arr[d_vc_q] : '0;
    done_o     = k_vld_q && (k_ack_q == lnk_pkg::ACK_TAKEN);
    retry_o    = k_vld_q && (k_ack_q != lnk_pkg::ACK_TAKEN);
    done_vc_o  = k_vc_q;
  end
endmodule

// File: rtl/lnk_rx.sv
// Receiving half: latches the identifier, then in the data step answers
// and writes only when the addressed buffer has room.
module lnk_rx #(
  parameter int DW          = 16,
  parameter int NUM_DIR     = 4,
  parameter int BUF_PER_MEM = 4,
  parameter int FREE_W      = 4
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           addr_vld_i,
  input  logic [lnk_pkg::idx_w(NUM_DIR*BUF_PER_MEM)-1:0] addr_i,
  input  logic                                           data_vld_i,
  input  logic [DW-1:0]                                  data_i,
  input  logic [NUM_DIR*BUF_PER_MEM*FREE_W-1:0]          free_i,
  output logic                                           ack_o,
  output logic                                           wr_en_o,
  output logic [lnk_pkg::idx_w(NUM_DIR)-1:0]             wr_dir_o,
  output logic [lnk_pkg::idx_w(BUF_PER_MEM)-1:0]         wr_idx_o,
  output logic [DW-1:0]                                  wr_data_o
);
  localparam int NBUF  = NUM_DIR * BUF_PER_MEM;
  localparam int ID_W  = lnk_pkg::idx_w(NBUF);
  localparam int DIR_W = lnk_pkg::idx_w(NUM_DIR);
  localparam int IDX_W = lnk_pkg::idx_w(BUF_PER_MEM);

  logic [FREE_W-1:0] free_arr [NBUF];

  generate
    for (genvar g = 0; g < NBUF; g++) begin : g_free
      assign free_arr[g] = free_i[g*FREE_W +: FREE_W];
    end
  endgenerate

  logic            r_vld_q;
  logic [ID_W-1:0] r_id_q;
  logic            p_vld_q;
  logic [ID_W-1:0] p_id_q;

  logic [DIR_W-1:0]  dec_dir;
  logic [IDX_W-1:0]  dec_idx;
  logic              active, same_buf, room;
  logic [FREE_W:0]   need;

  lnk_id_dec #(
    .NUM_DIR     (NUM_DIR),
    .BUF_PER_MEM (BUF_PER_MEM)
  ) u_dec (
    .id_i  (r_id_q),
    .dir_o (dec_dir),
    .idx_o (dec_idx)
  );

  // Space check, including the write made one cycle earlier.
  always_comb begin
    active   = r_vld_q && data_vld_i;
    same_buf = p_vld_q && (p_id_q == r_id_q);
    need     = (FREE_W+1)'(same_buf ? 2 : 1);
    room     = ({1'b0, free_arr[r_id_q]} >= need);
    ack_o    = active && room;
    wr_en_o  = ack_o;
    wr_dir_o = dec_dir;
    wr_idx_o = dec_idx;
    wr_data_o = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_vld_q <= 1'b0;
      p_vld_q <= 1'b0;
    end else begin
      r_vld_q <= addr_vld_i;
      p_vld_q <= ack_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_id_q <= '0;
      p_id_q <= '0;
    end else begin
      if (addr_vld_i) r_id_q <= addr_i;
      if (ack_o)      p_id_q <= r_id_q;
    end
  end
endmodule

// File: rtl/lnk_xfer_top.sv
module lnk_xfer_top #(
  parameter int NUM_VC      = 4,
  parameter int DW          = 16,
  parameter int NUM_DIR     = 4,
  parameter int BUF_PER_MEM = 4,
  parameter int FREE_W      = 4
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           arb_vld_i,
  input  logic [lnk_pkg::idx_w(NUM_VC)-1:0]              arb_vc_i,
  input  logic [NUM_VC*lnk_pkg::idx_w(NUM_DIR*BUF_PER_MEM)-1:0] route_tbl_i,
  input  logic [NUM_VC*DW-1:0]                           head_data_i,
  output logic                                           tx_done_o,
  output logic                                           tx_retry_o,
  output logic [lnk_pkg::idx_w(NUM_VC)-1:0]              tx_vc_o,
  output logic                                           lnk_addr_vld_o,
  output logic [lnk_pkg::idx_w(NUM_DIR*BUF_PER_MEM)-1:0] lnk_addr_o,
  output logic                                           lnk_data_vld_o,
  output logic [DW-1:0]                                  lnk_data_o,
  output logic                                           lnk_ack_o,
  input  logic [NUM_DIR*BUF_PER_MEM*FREE_W-1:0]          rx_free_i,
  output logic                                           rx_wr_en_o,
  output logic [lnk_pkg::idx_w(NUM_DIR)-1:0]             rx_wr_dir_o,
  output logic [lnk_pkg::idx_w(BUF_PER_MEM)-1:0]         rx_wr_idx_o,
  output logic [DW-1:0]                                  rx_wr_data_o
);
  localparam int ID_W = lnk_pkg::idx_w(NUM_DIR*BUF_PER_MEM);

  lnk_tx #(
    .NUM_VC (NUM_VC),
    .DW     (DW),
    .ID_W   (ID_W)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_vld_i (arb_vld_i),
    .grant_vc_i  (arb_vc_i),
    .route_i     (route_tbl_i),
    .head_i      (head_data_i),
    .ack_i       (lnk_ack_o),
    .addr_vld_o  (lnk_addr_vld_o),
    .addr_o      (lnk_addr_o),
    .data_vld_o  (lnk_data_vld_o),
    .data_o      (lnk_data_o),
    .done_o      (tx_done_o),
    .retry_o     (tx_retry_o),
    .done_vc_o   (tx_vc_o)
  );

  lnk_rx #(
    .DW          (DW),
    .NUM_DIR     (NUM_DIR),
    .BUF_PER_MEM (BUF_PER_MEM),
    .FREE_W      (FREE_W)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_vld_i (lnk_addr_vld_o),
    .addr_i     (lnk_addr_o),
    .data_vld_i (lnk_data_vld_o),
    .data_i     (lnk_data_o),
    .free_i     (rx_free_i),
    .ack_o      (lnk_ack_o),
    .wr_en_o    (rx_wr_en_o),
    .wr_dir_o   (rx_wr_dir_o),
    .wr_idx_o   (rx_wr_idx_o),
    .wr_data_o  (rx_wr_data_o)
  );
endmodule

// File: rtl/lnk_xfer_chk.sv
module lnk_xfer_chk #(
  parameter int NUM_DIR     = 4,
  parameter int BUF_PER_MEM = 4,
  parameter int FREE_W      = 4
) (
  input logic                                           clk,
  input logic                                           rst_n,
  input logic                                           tx_done_o,
  input logic                                           tx_retry_o,
  input logic                                           lnk_addr_vld_o,
  input logic [lnk_pkg::idx_w(NUM_DIR*BUF_PER_MEM)-1:0] lnk_addr_o,
  input logic                                           lnk_data_vld_o,
  input logic                                           lnk_ack_o,
  input logic [NUM_DIR*BUF_PER_MEM*FREE_W-1:0]          rx_free_i,
  input logic                                           rx_wr_en_o,
  input logic [lnk_pkg::idx_w(NUM_DIR)-1:0]             rx_wr_dir_o,
  input logic [lnk_pkg::idx_w(BUF_PER_MEM)-1:0]         rx_wr_idx_o
);
  localparam int DIR_W = lnk_pkg::idx_w(NUM_DIR);
  localparam int IDX_W = lnk_pkg::idx_w(BUF_PER_MEM);

  logic             pw_vld;
  logic [DIR_W-1:0] pw_dir;
  logic [IDX_W-1:0] pw_idx;
  int               cur_buf;
  logic [FREE_W-1:0] cur_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_vld <= 1'b0;
      pw_dir <= '0;
      pw_idx <= '0;
    end else begin
      pw_vld <= rx_wr_en_o;
      pw_dir <= rx_wr_dir_o;
      pw_idx <= rx_wr_idx_o;
    end
  end

  always_comb begin
    cur_buf  = int'(rx_wr_dir_o) * BUF_PER_MEM + int'(rx_wr_idx_o);
    cur_free = rx_free_i[cur_buf*FREE_W +: FREE_W];
  end

  // R1
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_addr_vld_o |=> lnk_data_vld_o);

  // R1
  data_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_data_vld_o |=> (tx_done_o || tx_retry_o));

  // R7
  single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done_o && tx_retry_o));

  // R7
  resp_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_o || tx_retry_o) |-> $past(lnk_data_vld_o));

  // R7
  done_tracks_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_data_vld_o |=> (tx_done_o == $past(lnk_ack_o)));

  // R4
  quiet_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_data_vld_o |-> !lnk_ack_o);

  // R5
  write_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en_o |-> lnk_data_vld_o);

  // R2
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_addr_vld_o |-> (lnk_addr_o == '0));

  // R6
  repeat_buf_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_en_o && pw_vld && (pw_dir == rx_wr_dir_o) && (pw_idx == rx_wr_idx_o))
      |-> (cur_free >= FREE_W'(2)));
endmodule

bind lnk_xfer_top lnk_xfer_chk #(
  .NUM_DIR     (NUM_DIR),
  .BUF_PER_MEM (BUF_PER_MEM),
  .FREE_W      (FREE_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_done_o      (tx_done_o),
  .tx_retry_o     (tx_retry_o),
  .lnk_addr_vld_o (lnk_addr_vld_o),
  .lnk_addr_o     (lnk_addr_o),
  .lnk_data_vld_o (lnk_data_vld_o),
  .lnk_ack_o      (lnk_ack_o),
  .rx_free_i      (rx_free_i),
  .rx_wr_en_o     (rx_wr_en_o),
  .rx_wr_dir_o    (rx_wr_dir_o),
  .rx_wr_idx_o    (rx_wr_idx_o)
);

// File: tb/lnk_xfer_top_tb.sv
module lnk_xfer_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int DW = 16;
  localparam int NB = 16;
  localparam int FW = 4;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n;
  logic arb_vld;
  logic [1:0] arb_vc;
  logic [NV*4-1:0] route_bus;
  logic [NV*DW-1:0] head_bus;
  logic [NB*FW-1:0] free_bus;
  logic tx_done, tx_retry;
  logic [1:0] tx_vc;
  logic addr_vld, data_vld, ack, wr_en;
  logic [3:0] addr;
  logic [DW-1:0] data, wr_data;
  logic [1:0] wr_dir, wr_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_xfer_top u_dut (
    .clk(clk), .rst_n(rst_n), .arb_vld_i(arb_vld), .arb_vc_i(arb_vc),
    .route_tbl_i(route_bus), .head_data_i(head_bus),
    .tx_done_o(tx_done), .tx_retry_o(tx_retry), .tx_vc_o(tx_vc),
    .lnk_addr_vld_o(addr_vld), .lnk_addr_o(addr),
    .lnk_data_vld_o(data_vld), .lnk_data_o(data), .lnk_ack_o(ack),
    .rx_free_i(free_bus), .rx_wr_en_o(wr_en), .rx_wr_dir_o(wr_dir),
    .rx_wr_idx_o(wr_idx), .rx_wr_data_o(wr_data)
  );

  int total = 0;
  int bad = 0;
  int route_m [NV];
  int cap [NB];
  int free_now [NB];
  int free_drv [NB];
  int seq [NV];
  int n_nack = 0, n_same_nack = 0, n_same_ack = 0, n_drop = 0, n_done = 0;

  // Reference history: l1 = launched last cycle, l2 = two cycles ago, l3 = three.
  bit l1_v, l2_v, l3_v, a1, w1_v;
  int l1_c, l2_c, l3_c, w1_b;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int head_val(input int c);
    return c * 4096 + (seq[c] % 4096);
  endfunction

  task automatic drive_buses();
    for (int i = 0; i < NV; i++) begin
      route_bus[i*4 +: 4] = 4'(route_m[i]);
      head_bus[i*DW +: DW] = DW'(head_val(i));
    end
    for (int b = 0; b < NB; b++) free_bus[b*FW +: FW] = FW'(free_drv[b]);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    route_m = '{5, 5, 14, 0};
    for (int b = 0; b < NB; b++) begin
      cap[b] = (b == 5) ? 2 : (b == 14 || b == 0) ? 1 : 3;
      free_now[b] = cap[b];
      free_drv[b] = cap[b];
    end
    for (int i = 0; i < NV; i++) seq[i] = 0;
    rst_n = 1'b0;
    arb_vld = 1'b1;
    arb_vc = 2'd0;
    drive_buses();
    repeat (3) @(negedge clk);
    #1;
    chk(!addr_vld, "R9 reset addr_vld", addr_vld, 0);
    chk(!data_vld, "R9 reset data_vld", data_vld, 0);
    chk(!ack,      "R9 reset ack", ack, 0);
    chk(!wr_en,    "R9 reset wr_en", wr_en, 0);
    chk(!tx_done,  "R9 reset done", tx_done, 0);
    chk(!tx_retry, "R9 reset retry", tx_retry, 0);
    @(negedge clk);
    rst_n = 1'b1;
    l1_v = 0; l2_v = 0; l3_v = 0; a1 = 0; w1_v = 0;
    l1_c = 0; l2_c = 0; l3_c = 0; w1_b = 0;

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      bit launch, e_ack, same;
      int tgt, need, e_addr, e_data;
      if (cyc > 0) @(negedge clk);
      arb_vld = (cyc % 1000) >= 900 ? 1'b0 : (($urandom % 10) < 7);
      arb_vc  = 2'($urandom % 4);
      drive_buses();
      #1;

      // Address step (R2) and four-step timing (R1).
      e_addr = l1_v ? route_m[l1_c] : 0;
      chk(addr_vld == l1_v, "R1 addr_vld", addr_vld, l1_v);
      chk(int'(addr) == e_addr, "R2 addr", addr, e_addr);

      // Data step (R3) and receiver answer (R4, R6).
      e_data = l2_v ? head_val(l2_c) : 0;
      chk(data_vld == l2_v, "R1 data_vld", data_vld, l2_v);
      chk(int'(data) == e_data, "R3 data", data, e_data);
      tgt  = route_m[l2_c];
      same = w1_v && (w1_b == tgt);
      need = same ? 2 : 1;
      e_ack = l2_v && (free_drv[tgt] >= need);
      chk(ack == e_ack, same ? "R6 ack same buffer" : "R4 ack", ack, e_ack);
      chk(wr_en == e_ack, "R5 wr_en", wr_en, e_ack);
      if (e_ack) begin
        chk(int'(wr_dir) == tgt / 4, "R5 wr_dir", wr_dir, tgt / 4);
        chk(int'(wr_idx) == tgt % 4, "R5 wr_idx", wr_idx, tgt % 4);
        chk(wr_data == DW'(e_data), "R5 wr_data", wr_data, e_data);
      end
      if (l2_v && !e_ack) n_nack++;
      if (l2_v && same && !e_ack && free_drv[tgt] >= 1) n_same_nack++;
      if (same && e_ack) n_same_ack++;

      // Acknowledge step (R7).
      chk(tx_done == (l3_v && a1), "R7 done", tx_done, l3_v && a1);
      chk(tx_retry == (l3_v && !a1), "R7 retry", tx_retry, l3_v && !a1);
      if (l3_v) chk(int'(tx_vc) == l3_c, "R7 vc", tx_vc, l3_c);

      // Grant acceptance (R8).
      launch = arb_vld && !(l1_v && l1_c == int'(arb_vc)) && !(l2_v && l2_c == int'(arb_vc));
      if (arb_vld && !launch) n_drop++;

      // Advance model for the coming edge.
      if (l3_v && a1) begin
        seq[l3_c]++;
        n_done++;
      end
      l3_v = l2_v; l3_c = l2_c; a1 = e_ack;
      l2_v = l1_v; l2_c = l1_c;
      l1_v = launch; l1_c = int'(arb_vc);
      w1_v = e_ack; w1_b = tgt;
      for (int b = 0; b < NB; b++) free_drv[b] = free_now[b];
      if (e_ack) free_now[tgt]--;
      for (int b = 0; b < NB; b++)
        if (free_now[b] < cap[b] && ($urandom % 4) == 0) free_now[b]++;
    end

    chk(n_nack > 0, "R4 full target refused at least once", n_nack, 1);
    chk(n_same_nack > 0, "R6 back-to-back same buffer refused", n_same_nack, 1);
    chk(n_same_ack > 0, "R6 back-to-back same buffer accepted", n_same_ack, 1);
    chk(n_drop > 0, "R8 in-flight grant dropped", n_drop, 1);
    chk(n_done > 100, "R7 words delivered", n_done, 100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule